// File: doc/BRIEF.md
# Loadable Burst Address Counter

This block generates the address that one port of a synchronous memory array uses in each cycle. On every rising clock edge it samples three active-low controls and an external address bus, and picks one of four actions. It can clear the address to zero, take the external address, step the previous address up by one, or keep the previous address. The result is held in a register whose output drives the array directly. Whatever address an edge selects is therefore the address accessed in the cycle that edge begins.

Bursts start with a load and then advance one location per cycle while the step control is held low. Pausing a burst (holding) repeats the last location, so a read returns the same data again. Clearing restarts at location zero with no idle cycle. Any action may follow any other on consecutive edges. The block looks only at its own controls, not at any chip-select, direction or output-enable state.

Top module: `burst_addr_counter`

## Requirements
- R1: When `adr_clear_n` is high and `adr_load_n` is low at a rising edge, `addr_o` equals the sampled `ext_addr_i` from that edge until the next edge.
- R2: When `adr_clear_n` and `adr_load_n` are high and `adr_step_n` is low at a rising edge, `addr_o` becomes its previous value plus one.
- R3: When all three controls are high at a rising edge, `addr_o` keeps its previous value and any value on `ext_addr_i` has no effect.
- R4: When `adr_clear_n` is low at a rising edge, `addr_o` becomes 0 in the cycle that follows, whatever `adr_load_n`, `adr_step_n` and `ext_addr_i` are.
- R5: When `adr_load_n` and `adr_step_n` are both low (clear high), the load wins and `addr_o` equals `ext_addr_i`, not the previous value plus one.
- R6: Stepping from the all-ones address (0xFFFF at the default width) gives 0x0000.
- R7: While `rst_n` is low at a rising edge, `addr_o` becomes 0. This reset overrides every control input.
- R8: Clear, load, step and hold may follow each other on consecutive edges in any order. Each takes effect on its own edge with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low system reset |
| ext_addr_i | input | ADDR_W (16) | External address, taken when the load control is low |
| adr_load_n | input | 1 | Active-low address load strobe |
| adr_step_n | input | 1 | Active-low count enable |
| adr_clear_n | input | 1 | Active-low counter clear, highest priority |
| addr_o | output | ADDR_W (16) | Address used by the array in the current cycle |

## Verification
The assertions assume that the controls and the external address are stable across each rising edge. They also assume that `rst_n` is held low for at least one edge before any control is exercised. Under those assumptions, `$past` of the inputs is the value the register actually sampled. The bench meets both conditions by changing every input only on the falling edge and by starting with several reset cycles. Control combinations that overlap, such as clear with load, or load with step, are driven deliberately so that the priority properties are exercised and not left vacuous.

// File: rtl/bac_pkg.sv
// Package: shared types for the burst address counter.
// Assumes: nothing; pure type definitions.
package bac_pkg;

    // Action chosen for the next address on a clock edge.
    typedef enum logic [1:0] {
        BAC_HOLD  = 2'd0,
        BAC_STEP  = 2'd1,
        BAC_LOAD  = 2'd2,
        BAC_CLEAR = 2'd3
    } bac_op_e;

endpackage

// File: rtl/bac_op_decode.sv
// Module: bac_op_decode
// Turns the three active-low controls into one action, applying the
// fixed priority clear > load > step > hold.
// Assumes: inputs are already synchronous to the counter clock.
module bac_op_decode
    import bac_pkg::*;
(
    input  logic    clear_n,
    input  logic    load_n,
    input  logic    step_n,
    output bac_op_e op
);

    // Priority encode the controls into a single action.
    always_comb begin
        if (!clear_n) begin
            op = BAC_CLEAR;
        end else if (!load_n) begin
            op = BAC_LOAD;
        end else if (!step_n) begin
            op = BAC_STEP;
        end else begin
            op = BAC_HOLD;
        end
    end

endmodule

// File: rtl/bac_incr.sv
// Module: bac_incr
// Adds one to an address, wrapping from all ones to zero.
// RIPPLE=1 builds an explicit carry chain; RIPPLE=0 leaves the adder
// to the synthesis tool.
// Assumes: purely combinational; no overflow flag is needed.
module bac_incr #(
    parameter int W      = 16,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] carry;
            // Seed the chain with the +1.
            assign carry[0] = 1'b1;
            for (genvar i = 0; i < W; i++) begin : g_bit
                // Half adder per bit; the final carry is dropped for wrap.
                assign y[i]       = a[i] ^ carry[i];
                assign carry[i+1] = a[i] & carry[i];
            end
        end else begin : g_behav
            // Let the tool choose the adder structure.
            assign y = a + W'(1);
        end
    endgenerate

endmodule

// File: rtl/bac_addr_reg.sv
// Module: bac_addr_reg
// Selects the next address from the decoded action and stores it.
// The stored value is the address used in the cycle after the edge.
// Assumes: rst_n is synchronous and active low.
module bac_addr_reg
    import bac_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bac_op_e      op,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] inc_val,
    output logic [W-1:0] q
);

    logic [W-1:0] next_q;

    // Pick the next address for the selected action.
    always_comb begin
        unique case (op)
            BAC_CLEAR: next_q = '0;
            BAC_LOAD:  next_q = load_val;
            BAC_STEP:  next_q = inc_val;
            default:   next_q = q;
        endcase
    end

    // Store the selected address; system reset forces zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= next_q;
        end
    end

    // R7: after a reset edge the register reads zero.
    assert_sysreset_zero_R7: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

endmodule

// File: rtl/burst_addr_counter.sv
// Module: burst_addr_counter
// Per-port address generator in front of a synchronous memory array.
// Clears, loads, advances or holds the address on each rising edge,
// with no idle cycle between actions.
// Assumes: one clock domain; inputs meet setup/hold to clk.
module burst_addr_counter #(
    parameter int ADDR_W     = 16,
    parameter bit INC_RIPPLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr_i,
    input  logic              adr_load_n,
    input  logic              adr_step_n,
    input  logic              adr_clear_n,
    output logic [ADDR_W-1:0] addr_o
);
    import bac_pkg::*;

    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    bac_op_e           op;
    logic [ADDR_W-1:0] addr_inc;

    bac_op_decode u_decode (
        .clear_n (adr_clear_n),
        .load_n  (adr_load_n),
        .step_n  (adr_step_n),
        .op      (op)
    );

    bac_incr #(
        .W      (ADDR_W),
        .RIPPLE (INC_RIPPLE)
    ) u_incr (
        .a (addr_o),
        .y (addr_inc)
    );

    bac_addr_reg #(
        .W (ADDR_W)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (ext_addr_i),
        .inc_val  (addr_inc),
        .q        (addr_o)
    );

    // R4: clear forces zero regardless of other controls.
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_clear_n |=> (addr_o == '0));

    // R1 and R5: load takes the bus value even when step is also low.
    assert_load_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_clear_n && !adr_load_n) |=> (addr_o == $past(ext_addr_i)));

    // R2: step alone advances by one.
    assert_step_plus_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_clear_n && adr_load_n && !adr_step_n)
            |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

    // R3: no control active keeps the address.
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_clear_n && adr_load_n && adr_step_n) |=> $stable(addr_o));

    // R6: stepping from all ones lands on zero.
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_clear_n && adr_load_n && !adr_step_n && addr_o == ALL_ONES)
            |=> (addr_o == '0));

endmodule

// File: tb/burst_addr_counter_tb.sv
// Directed bench for burst_addr_counter: one task per scenario.
module burst_addr_counter_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] ext_addr_i;
    logic         adr_load_n;
    logic         adr_step_n;
    logic         adr_clear_n;
    logic [W-1:0] addr_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    burst_addr_counter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_addr_i  (ext_addr_i),
        .adr_load_n  (adr_load_n),
        .adr_step_n  (adr_step_n),
        .adr_clear_n (adr_clear_n),
        .addr_o      (addr_o)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Compare the output with the expected address.
    task automatic check(input logic [W-1:0] exp, input string req);
        checks++;
        if (addr_o !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, addr_o, exp);
        end
    endtask

    // Drive one cycle at a falling edge, check at the next falling edge.
    task automatic cyc(input logic clr, input logic ld, input logic st,
                       input logic [W-1:0] a, input logic [W-1:0] exp,
                       input string req);
        adr_clear_n = clr;
        adr_load_n  = ld;
        adr_step_n  = st;
        ext_addr_i  = a;
        @(negedge clk);
        check(exp, req);
    endtask

    // R7: reset state, and reset beats a load.
    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1, 1, 1, 16'h1234, 16'h0000, "R7");
        cyc(1, 0, 0, 16'hBEEF, 16'h0000, "R7");
        cyc(1, 1, 1, 16'h0000, 16'h0000, "R7");
        rst_n = 1'b1;
    endtask

    // R1: loads of several patterns.
    task automatic t_load();
        cyc(1, 0, 1, 16'h00A5, 16'h00A5, "R1");
        cyc(1, 0, 1, 16'h5A00, 16'h5A00, "R1");
        cyc(1, 0, 1, 16'hFFFE, 16'hFFFE, "R1");
    endtask

    // R2: burst advance from a loaded start.
    task automatic t_step();
        cyc(1, 0, 1, 16'h0100, 16'h0100, "R1");
        for (int i = 1; i <= 4; i++) begin
            cyc(1, 1, 0, 16'hDEAD, 16'(16'h0100 + i), "R2");
        end
    endtask

    // R3: hold ignores a changing bus.
    task automatic t_hold();
        cyc(1, 0, 1, 16'h0777, 16'h0777, "R1");
        cyc(1, 1, 1, 16'h1111, 16'h0777, "R3");
        cyc(1, 1, 1, 16'hFFFF, 16'h0777, "R3");
        cyc(1, 1, 0, 16'h0000, 16'h0778, "R2");
    endtask

    // R4 and R5: clear beats load and step; load beats step.
    task automatic t_priority();
        cyc(1, 0, 1, 16'h4321, 16'h4321, "R1");
        cyc(0, 0, 0, 16'h9999, 16'h0000, "R4");
        cyc(1, 0, 0, 16'h2222, 16'h2222, "R5");
        cyc(0, 1, 0, 16'h3333, 16'h0000, "R4");
        cyc(1, 1, 0, 16'h3333, 16'h0001, "R2");
    endtask

    // R6: wrap from all ones.
    task automatic t_wrap();
        cyc(1, 0, 1, 16'hFFFF, 16'hFFFF, "R1");
        cyc(1, 1, 0, 16'h0000, 16'h0000, "R6");
        cyc(1, 1, 0, 16'h0000, 16'h0001, "R6");
    endtask

    // R8: every action on consecutive edges.
    task automatic t_back_to_back();
        cyc(1, 0, 1, 16'h8000, 16'h8000, "R8");
        cyc(1, 1, 0, 16'h0000, 16'h8001, "R8");
        cyc(1, 1, 1, 16'h0000, 16'h8001, "R8");
        cyc(0, 1, 1, 16'h0000, 16'h0000, "R8");
        cyc(1, 1, 0, 16'h0000, 16'h0001, "R8");
        cyc(1, 0, 1, 16'h00C0, 16'h00C0, "R8");
        cyc(0, 1, 1, 16'h0000, 16'h0000, "R8");
        cyc(1, 0, 0, 16'h7FFF, 16'h7FFF, "R8");
    endtask

    // Main sequence.
    initial begin
        rst_n       = 1'b0;
        adr_clear_n = 1'b1;
        adr_load_n  = 1'b1;
        adr_step_n  = 1'b1;
        ext_addr_i  = '0;
        @(negedge clk);
        t_reset();
        t_load();
        t_step();
        t_hold();
        t_priority();
        t_wrap();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule